// File: doc/BRIEF.md
# Core Special Function Register Group

This block holds the architectural working registers that an 8-bit controller core keeps in its special function register space: an accumulator, a scratch B register, a status word, an 8-bit stack pointer and a 16-bit data pointer. The core reaches them over a byte-wide register bus. Each access carries an address and a read strobe or a write strobe. Reads are combinational and writes take effect at the clock edge.

Beside the bus, the block keeps three registers up to date on its own. The lowest bit of the status word always shows the parity of the accumulator. Two status bits choose one of four 8-byte working-register banks, and the block outputs the base RAM address of the chosen bank. A push request and a pop request move the stack pointer, and the block outputs the internal RAM address that the current stack access uses. A data pointer increment request adds one to the full 16-bit pointer in a single cycle. Addresses that no register occupies are decoded: a write to one changes nothing, and a read from one returns zero.

Top module: `sfr_core_regs`

## Requirements
- R1: After reset the accumulator, B, the stored status flags and both data pointer bytes hold 00H, and the stack pointer holds 07H.
- R2: With the write strobe high, a write at the clock edge loads the register at its address: accumulator E0H, B F0H, status D0H, stack pointer 81H, pointer low byte 82H, pointer high byte 83H. While the read strobe is high, `busRdData` shows that register in the same cycle. While the read strobe is low, `busRdData` is 00H.
- R3: Status bit 0 is 1 exactly when the accumulator holds an odd number of 1 bits. A bus write to bit 0 is ignored, and bits 7..1 keep the written values.
- R4: `bankBase` equals 8 times the two bank-select bits, which are status bits 4 (upper) and 3 (lower): 00H, 08H, 10H or 18H.
- R5: During a push cycle `stackAddr` is the stack pointer plus one, and after the edge the stack pointer holds that value.
- R6: During a pop cycle, with no push, `stackAddr` is the current stack pointer, and after the edge the stack pointer is one lower.
- R7: A push and a pop in the same cycle act as a push only. A push or pop overrides a bus write to the stack pointer in the same cycle.
- R8: A data pointer increment adds one to the 16-bit value {high, low} in one cycle, carrying from the low byte into the high byte, and wraps from FFFFH to 0000H.
- R9: When the bus writes either data pointer byte in the same cycle as an increment request, the write takes effect and the increment is dropped.
- R10: A write to any address not listed in R2 leaves every register unchanged, and a read from such an address returns 00H.
- R11: The stack pointer wraps from FFH to 00H on a push and from 00H to FFH on a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busAddr | input | 8 | Register bus address |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational |
| pushReq | input | 1 | Pre-increment the stack pointer |
| popReq | input | 1 | Post-decrement the stack pointer |
| dptrInc | input | 1 | Increment the 16-bit data pointer |
| stackAddr | output | 8 | Internal RAM address for the current stack access |
| accOut | output | 8 | Accumulator value |
| pswOut | output | 8 | Status word with live parity in bit 0 |
| spOut | output | 8 | Stack pointer value |
| dptrOut | output | 16 | Data pointer {high, low} |
| bankBase | output | 8 | Base RAM address of the working register bank |

## Verification
The properties assume that the inputs are known, 0 or 1, in every cycle after reset. They also assume that the bus never raises the read and write strobes in the same cycle to check one register's read path against a write at the same edge. The stack and pointer properties rely on the priority rules of R7 and R9. The unchanged-state property for unused addresses therefore applies only in cycles with no push, pop or increment request. The directed bench drives every input on the falling edge, with a single strobe active per bus access. The simultaneous cases are driven only in the tasks that exercise R7 and R9.

// File: rtl/sfr_core_pkg.sv
package sfr_core_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int PTR_W  = 2 * DATA_W;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ACC,
    SEL_B,
    SEL_PSW,
    SEL_SP,
    SEL_DPL,
    SEL_DPH
  } rdSel_e;

  typedef struct packed {
    logic   wrAcc;
    logic   wrB;
    logic   wrPsw;
    logic   wrSp;
    logic   wrDpl;
    logic   wrDph;
    logic   spInc;
    logic   spDec;
    logic   dpInc;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/sfr_core_ctrl.sv
module sfr_core_ctrl
  import sfr_core_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ADDR_ACC = 8'hE0,
  parameter logic [ADDR_W-1:0] ADDR_B   = 8'hF0,
  parameter logic [ADDR_W-1:0] ADDR_PSW = 8'hD0,
  parameter logic [ADDR_W-1:0] ADDR_SP  = 8'h81,
  parameter logic [ADDR_W-1:0] ADDR_DPL = 8'h82,
  parameter logic [ADDR_W-1:0] ADDR_DPH = 8'h83
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic              dptrInc,
  output strobes_t          stb
);

  logic hitAcc, hitB, hitPsw, hitSp, hitDpl, hitDph;
  logic stackOp;
  rdSel_e decSel;

  assign hitAcc = (busAddr == ADDR_ACC);
  assign hitB   = (busAddr == ADDR_B);
  assign hitPsw = (busAddr == ADDR_PSW);
  assign hitSp  = (busAddr == ADDR_SP);
  assign hitDpl = (busAddr == ADDR_DPL);
  assign hitDph = (busAddr == ADDR_DPH);

  assign stackOp = pushReq | popReq;

  always_comb begin
    decSel = SEL_NONE;
    if (hitAcc)      decSel = SEL_ACC;
    else if (hitB)   decSel = SEL_B;
    else if (hitPsw) decSel = SEL_PSW;
    else if (hitSp)  decSel = SEL_SP;
    else if (hitDpl) decSel = SEL_DPL;
    else if (hitDph) decSel = SEL_DPH;
  end

  always_comb begin
    stb.wrAcc = busWrEn & hitAcc;
    stb.wrB   = busWrEn & hitB;
    stb.wrPsw = busWrEn & hitPsw;
    // stack motion has priority over a bus load of the pointer
    stb.wrSp  = busWrEn & hitSp & ~stackOp;
    stb.wrDpl = busWrEn & hitDpl;
    stb.wrDph = busWrEn & hitDph;
    stb.spInc = pushReq;
    stb.spDec = popReq & ~pushReq;
    // a byte load of the pointer drops the increment for that cycle
    stb.dpInc = dptrInc & ~(busWrEn & (hitDpl | hitDph));
    stb.rdSel = busRdEn ? decSel : SEL_NONE;
  end

endmodule

// File: rtl/sfr_core_dp.sv
module sfr_core_dp
  import sfr_core_pkg::*;
#(
  parameter logic [DATA_W-1:0] SP_RESET = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] stackAddr,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] pswOut,
  output logic [DATA_W-1:0] spOut,
  output logic [PTR_W-1:0]  dptrOut,
  output logic [DATA_W-1:0] bankBase
);

  localparam int BANK_SHIFT = 3;
  localparam int RS_LO      = 3;
  localparam int RS_HI      = 4;

  logic [DATA_W-1:0] accReg, bReg, spReg, dplReg, dphReg;
  logic [DATA_W-1:1] flagReg;
  logic [DATA_W-1:0] parityChain;
  logic [DATA_W-1:0] spNext;
  logic [PTR_W-1:0]  dptrSum;

  // ripple parity chain across the accumulator bits
  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_par
      if (gi == 0) begin : g_first
        assign parityChain[gi] = accReg[gi];
      end else begin : g_rest
        assign parityChain[gi] = parityChain[gi-1] ^ accReg[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accReg  <= '0;
      bReg    <= '0;
      flagReg <= '0;
    end else begin
      if (stb.wrAcc) accReg  <= wrData;
      if (stb.wrB)   bReg    <= wrData;
      if (stb.wrPsw) flagReg <= wrData[DATA_W-1:1];
    end
  end

  always_comb begin
    spNext = spReg;
    if (stb.spInc)      spNext = spReg + 1'b1;
    else if (stb.spDec) spNext = spReg - 1'b1;
    else if (stb.wrSp)  spNext = wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spReg <= SP_RESET;
    else        spReg <= spNext;
  end

  assign dptrSum = {dphReg, dplReg} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dplReg <= '0;
      dphReg <= '0;
    end else if (stb.dpInc) begin
      {dphReg, dplReg} <= dptrSum;
    end else begin
      if (stb.wrDpl) dplReg <= wrData;
      if (stb.wrDph) dphReg <= wrData;
    end
  end

  assign pswOut    = {flagReg, parityChain[DATA_W-1]};
  assign accOut    = accReg;
  assign spOut     = spReg;
  assign dptrOut   = {dphReg, dplReg};
  assign stackAddr = stb.spInc ? (spReg + 1'b1) : spReg;

  always_comb begin
    bankBase = '0;
    bankBase[BANK_SHIFT +: 2] = {flagReg[RS_HI], flagReg[RS_LO]};
  end

  always_comb begin
    unique case (stb.rdSel)
      SEL_ACC: rdData = accReg;
      SEL_B:   rdData = bReg;
      SEL_PSW: rdData = pswOut;
      SEL_SP:  rdData = spReg;
      SEL_DPL: rdData = dplReg;
      SEL_DPH: rdData = dphReg;
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/sfr_core_regs.sv
module sfr_core_regs
  import sfr_core_pkg::*;
#(
  parameter logic [DATA_W-1:0] SP_RESET = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic              dptrInc,
  output logic [DATA_W-1:0] stackAddr,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] pswOut,
  output logic [DATA_W-1:0] spOut,
  output logic [PTR_W-1:0]  dptrOut,
  output logic [DATA_W-1:0] bankBase
);

  strobes_t stb;

  sfr_core_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .pushReq (pushReq),
    .popReq  (popReq),
    .dptrInc (dptrInc),
    .stb     (stb)
  );

  sfr_core_dp #(.SP_RESET(SP_RESET)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .wrData    (busWrData),
    .rdData    (busRdData),
    .stackAddr (stackAddr),
    .accOut    (accOut),
    .pswOut    (pswOut),
    .spOut     (spOut),
    .dptrOut   (dptrOut),
    .bankBase  (bankBase)
  );

endmodule

// File: rtl/sfr_core_regs_chk.sv
module sfr_core_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  busAddr,
  input logic        busWrEn,
  input logic        busRdEn,
  input logic [7:0]  busWrData,
  input logic [7:0]  busRdData,
  input logic        pushReq,
  input logic        popReq,
  input logic        dptrInc,
  input logic [7:0]  stackAddr,
  input logic [7:0]  accOut,
  input logic [7:0]  pswOut,
  input logic [7:0]  spOut,
  input logic [15:0] dptrOut,
  input logic [7:0]  bankBase
);

  logic mapped;
  logic quiet;
  assign mapped = (busAddr == 8'hE0) || (busAddr == 8'hF0) || (busAddr == 8'hD0) ||
                  (busAddr == 8'h81) || (busAddr == 8'h82) || (busAddr == 8'h83);
  assign quiet  = !pushReq && !popReq && !dptrInc;

  // R2: accumulator load lands at the edge
  a_r2_acc_load: assert property (@(posedge clk) disable iff (!rst_n)
    busWrEn && busAddr == 8'hE0 |=> accOut == $past(busWrData));

  // R3: status read shows live accumulator parity
  a_r3_parity_read: assert property (@(posedge clk) disable iff (!rst_n)
    busRdEn && busAddr == 8'hD0 |-> busRdData[0] == ^accOut);

  // R4: bank base follows the select bits
  a_r4_bank_base: assert property (@(posedge clk) disable iff (!rst_n)
    bankBase == {3'b000, pswOut[4:3], 3'b000});

  // R5: pre-increment address and pointer update
  a_r5_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
    pushReq |-> stackAddr == 8'(spOut + 8'd1));
  a_r5_push_sp: assert property (@(posedge clk) disable iff (!rst_n)
    pushReq |=> spOut == 8'($past(spOut) + 8'd1));

  // R6: post-decrement on pop
  a_r6_pop_addr: assert property (@(posedge clk) disable iff (!rst_n)
    popReq && !pushReq |-> stackAddr == spOut);
  a_r6_pop_sp: assert property (@(posedge clk) disable iff (!rst_n)
    popReq && !pushReq |=> spOut == 8'($past(spOut) - 8'd1));

  // R8: single-cycle carry into the high byte
  a_r8_dptr_inc: assert property (@(posedge clk) disable iff (!rst_n)
    dptrInc && !(busWrEn && (busAddr == 8'h82 || busAddr == 8'h83))
    |=> dptrOut == 16'($past(dptrOut) + 16'd1));

  // R10: unused addresses leave state alone
  a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    busWrEn && !mapped && quiet
    |=> $stable(accOut) && $stable(pswOut) && $stable(spOut) && $stable(dptrOut));
  a_r10_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    busRdEn && !mapped |-> busRdData == 8'h00);

endmodule

bind sfr_core_regs sfr_core_regs_chk u_chk (.*);

// File: tb/sfr_core_regs_bench.sv
module sfr_core_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        pushReq = 1'b0;
  logic        popReq = 1'b0;
  logic        dptrInc = 1'b0;
  logic [7:0]  stackAddr, accOut, pswOut, spOut, bankBase;
  logic [15:0] dptrOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sfr_core_regs u_sfr_core_regs (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .pushReq(pushReq), .popReq(popReq), .dptrInc(dptrInc),
    .stackAddr(stackAddr), .accOut(accOut), .pswOut(pswOut),
    .spOut(spOut), .dptrOut(dptrOut), .bankBase(bankBase)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, {8'h00, v}, {8'h00, exp});
  endtask

  task automatic testReset();
    expectReg("R1 acc", 8'hE0, 8'h00);
    expectReg("R1 b", 8'hF0, 8'h00);
    expectReg("R1 psw", 8'hD0, 8'h00);
    expectReg("R1 sp", 8'h81, 8'h07);
    expectReg("R1 dpl", 8'h82, 8'h00);
    expectReg("R1 dph", 8'h83, 8'h00);
  endtask

  task automatic testReadWrite();
    wr(8'hE0, 8'hA5); wr(8'hF0, 8'h3C); wr(8'h81, 8'h20);
    wr(8'h82, 8'h11); wr(8'h83, 8'h22);
    expectReg("R2 acc", 8'hE0, 8'hA5);
    expectReg("R2 b", 8'hF0, 8'h3C);
    expectReg("R2 sp", 8'h81, 8'h20);
    expectReg("R2 dpl", 8'h82, 8'h11);
    expectReg("R2 dph", 8'h83, 8'h22);
    @(negedge clk); busAddr = 8'hE0; busRdEn = 1'b0; #1;
    check("R2 idle read", {8'h00, busRdData}, 16'h0000);
  endtask

  task automatic testParity();
    check("R3 even acc", {15'h0, pswOut[0]}, 16'h0000);
    wr(8'hE0, 8'h07);
    check("R3 odd acc", {15'h0, pswOut[0]}, 16'h0001);
    wr(8'hD0, 8'hE6);
    expectReg("R3 psw flags kept, bit0 live", 8'hD0, 8'hE7);
    wr(8'hD0, 8'h01);
    wr(8'hE0, 8'h00);
    expectReg("R3 bit0 write ignored", 8'hD0, 8'h00);
  endtask

  task automatic testBanks();
    for (int i = 0; i < 4; i++) begin
      wr(8'hD0, 8'(i << 3));
      check("R4 bank base", {8'h00, bankBase}, 16'(i * 8));
    end
    wr(8'hD0, 8'hE7);
    check("R4 other bits no effect", {8'h00, bankBase}, 16'h0000);
    wr(8'hD0, 8'h00);
  endtask

  task automatic stackStep(input string req, input bit p, input bit q,
                           input logic [7:0] expAddr, input logic [7:0] expSp);
    @(negedge clk);
    pushReq = p; popReq = q;
    #1 check({req, " addr"}, {8'h00, stackAddr}, {8'h00, expAddr});
    @(negedge clk);
    pushReq = 1'b0; popReq = 1'b0;
    #1 check({req, " sp"}, {8'h00, spOut}, {8'h00, expSp});
  endtask

  task automatic testStack();
    wr(8'h81, 8'h07);
    stackStep("R5 push", 1'b1, 1'b0, 8'h08, 8'h08);
    stackStep("R5 push2", 1'b1, 1'b0, 8'h09, 8'h09);
    stackStep("R6 pop", 1'b0, 1'b1, 8'h09, 8'h08);
    stackStep("R7 push and pop", 1'b1, 1'b1, 8'h09, 8'h09);
    @(negedge clk);
    busAddr = 8'h81; busWrData = 8'h55; busWrEn = 1'b1; popReq = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; popReq = 1'b0;
    #1 check("R7 pop beats bus write", {8'h00, spOut}, 16'h0008);
  endtask

  task automatic testStackWrap();
    wr(8'h81, 8'hFF);
    stackStep("R11 push wrap", 1'b1, 1'b0, 8'h00, 8'h00);
    stackStep("R11 pop wrap", 1'b0, 1'b1, 8'h00, 8'hFF);
  endtask

  task automatic incOnce();
    @(negedge clk); dptrInc = 1'b1;
    @(negedge clk); dptrInc = 1'b0;
    #1;
  endtask

  task automatic testDptr();
    wr(8'h82, 8'hFF); wr(8'h83, 8'h12);
    incOnce();
    check("R8 carry", dptrOut, 16'h1300);
    wr(8'h83, 8'hFF); wr(8'h82, 8'hFF);
    incOnce();
    check("R8 wrap", dptrOut, 16'h0000);
    wr(8'h82, 8'h34);
    incOnce();
    check("R8 low only", dptrOut, 16'h0035);
    @(negedge clk);
    busAddr = 8'h82; busWrData = 8'h80; busWrEn = 1'b1; dptrInc = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; dptrInc = 1'b0;
    #1 check("R9 write wins over inc", dptrOut, 16'h0080);
  endtask

  task automatic testUnmapped();
    wr(8'hE0, 8'h5A); wr(8'h81, 8'h30);
    wr(8'h90, 8'hFF); wr(8'hE1, 8'hFF); wr(8'h80, 8'hFF);
    check("R10 acc unchanged", {8'h00, accOut}, 16'h005A);
    check("R10 sp unchanged", {8'h00, spOut}, 16'h0030);
    check("R10 dptr unchanged", dptrOut, 16'h0080);
    check("R10 psw unchanged", {8'h00, pswOut}, 16'h0000);
    expectReg("R10 b unchanged", 8'hF0, 8'h3C);
    expectReg("R10 unmapped read", 8'h90, 8'h00);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 spOut", {8'h00, spOut}, 16'h0007);
    testReset();
    testReadWrite();
    testParity();
    testBanks();
    testStack();
    testStackWrap();
    testDptr();
    testUnmapped();
    finishRun();
  end

endmodule